// File: doc/BRIEF.md
# DMA Interrupt Status Aggregator

This block gathers completion events from a set of DMA channels and folds them into a single interrupt line. Each channel keeps a sticky cause register of five bits and a five-bit mask register. A cause bit that is both set and unmasked counts as enabled. When a channel gains a new enabled cause, its bit in a shared pending register sets. The interrupt line is driven from the pending bits that are also allowed by a global enable register.

Pending and channel causes are cleared through separate writes. Software normally clears the pending bit and then the channel's causes. Until it does so, a channel can still hold causes while its pending bit is already low. The register port also reports, for each channel, whether that channel is idle, taken from the per-channel busy inputs.

Register map (word addresses): 0 pending (bit c = channel c), 1 global enable, 2 idle, then for channel c the cause register at 4+2c and the mask register at 5+2c. The cause bits are: bit 0 block done, bit 1 super-block done, bit 2 frame done, bit 3 half frame, bit 4 last frame.

Top module: `dma_irq_agg`

## Requirements
- R1: After reset the pending, global enable, cause and mask registers all read 0, and `irq_o` is low.
- R2: A high on `cause_i[5c+k]` for one cycle sets bit k of channel c's cause register. The bit stays set until software clears it.
- R3: A write to a channel's cause register keeps the bits written 1 and clears the bits written 0, so writing 0 clears every cause of that channel.
- R4: If a cause event and a write to the same cause register fall in the same cycle, the event's bit ends up set.
- R5: A channel's pending bit sets on the same clock edge at which that channel gains an enabled cause (cause bit and mask bit both 1). A cause that is masked does not set pending.
- R6: Writing 1 to a pending bit clears it, and writing 0 leaves it unchanged. If a new enabled cause arrives in the same cycle as the clear, the bit stays set.
- R7: Clearing a pending bit leaves that channel's cause register unchanged.
- R8: `irq_o` is high exactly when some channel has both its pending bit and its global enable bit set.
- R9: Reading the idle register returns bit c high when `busy_i[c]` is low.
- R10: Read data appears on `bus_rdata` in the cycle after the read is accepted. Unmapped addresses read 0.
- R11: The mask register stores the low five bits of the written data and reads them back, with the upper bits as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cause_i | input | NCH*5 | One-cycle cause events, bit 5c+k for channel c cause k |
| busy_i | input | NCH | Channel busy indications |
| bus_valid | input | 1 | Register access request |
| bus_write | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | AW | Word address |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data, valid the cycle after a read |
| irq_o | output | 1 | Combined interrupt |

## Verification
The bench targets the cycles where two actions meet. In one, a cause event arrives during a write that clears the same cause register; a design where the write wins would lose the event. In another, an enabled cause arrives during a write-1 clear of pending; a design where the clear wins would drop the interrupt. The bench also checks that clearing pending leaves the channel's causes in place, since a design that tied the two levels together would wipe them. It checks that a masked cause leaves pending untouched, and that unmasking an already-set cause raises pending on that same edge, to catch an off-by-one-cycle pending update.

// File: rtl/dma_irq_agg.sv
module dma_irq_agg #(
  parameter int NCH = 4,
  parameter int AW  = 6,
  parameter int DW  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH*5-1:0]  cause_i,
  input  logic [NCH-1:0]    busy_i,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [AW-1:0]     bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic              irq_o
);
  localparam int NC       = 5;
  localparam int ADR_PEND = 0;
  localparam int ADR_GEN  = 1;
  localparam int ADR_IDLE = 2;
  localparam int ADR_CH0  = 4;

  logic [NCH*NC-1:0] stat_q, stat_n, mask_q, mask_n;
  logic [NCH-1:0]    pend_q, pend_n, gen_q, set_ev, clr_w1c;

  wire wr = bus_valid && bus_write;
  wire rd = bus_valid && !bus_write;

  assign clr_w1c = (wr && bus_addr == AW'(ADR_PEND)) ? bus_wdata[NCH-1:0] : '0;

  always_comb begin
    stat_n = stat_q;
    mask_n = mask_q;
    for (int c = 0; c < NCH; c++) begin
      if (wr && bus_addr == AW'(ADR_CH0 + 2*c))
        stat_n[c*NC +: NC] = stat_q[c*NC +: NC] & bus_wdata[NC-1:0];
      stat_n[c*NC +: NC] = stat_n[c*NC +: NC] | cause_i[c*NC +: NC];
      if (wr && bus_addr == AW'(ADR_CH0 + 2*c + 1))
        mask_n[c*NC +: NC] = bus_wdata[NC-1:0];
      set_ev[c] = |(stat_n[c*NC +: NC] & mask_n[c*NC +: NC]
                    & ~(stat_q[c*NC +: NC] & mask_q[c*NC +: NC]));
    end
    pend_n = (pend_q & ~clr_w1c) | set_ev;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_q <= '0;
      mask_q <= '0;
      pend_q <= '0;
      gen_q  <= '0;
    end else begin
      stat_q <= stat_n;
      mask_q <= mask_n;
      pend_q <= pend_n;
      if (wr && bus_addr == AW'(ADR_GEN)) gen_q <= bus_wdata[NCH-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rdata <= '0;
    end else begin
      bus_rdata <= '0;
      if (rd) begin
        if (bus_addr == AW'(ADR_PEND)) bus_rdata[NCH-1:0] <= pend_q;
        if (bus_addr == AW'(ADR_GEN))  bus_rdata[NCH-1:0] <= gen_q;
        if (bus_addr == AW'(ADR_IDLE)) bus_rdata[NCH-1:0] <= ~busy_i;
        for (int c = 0; c < NCH; c++) begin
          if (bus_addr == AW'(ADR_CH0 + 2*c))     bus_rdata[NC-1:0] <= stat_q[c*NC +: NC];
          if (bus_addr == AW'(ADR_CH0 + 2*c + 1)) bus_rdata[NC-1:0] <= mask_q[c*NC +: NC];
        end
      end
    end
  end

  assign irq_o = |(pend_q & gen_q);
endmodule

module dma_irq_agg_chk #(
  parameter int NCH = 4,
  parameter int AW  = 6,
  parameter int DW  = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NCH*5-1:0]  cause_i,
  input logic [NCH-1:0]    busy_i,
  input logic              bus_valid,
  input logic              bus_write,
  input logic [AW-1:0]     bus_addr,
  input logic [DW-1:0]     bus_wdata,
  input logic [DW-1:0]     bus_rdata,
  input logic              irq_o,
  input logic [NCH*5-1:0]  stat_q,
  input logic [NCH-1:0]    pend_q,
  input logic [NCH-1:0]    gen_q
);
  localparam int ADR_PEND = 0;
  localparam int ADR_IDLE = 2;
  localparam int ADR_CH0  = 4;

  AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (|(pend_q & gen_q))); // R8

  AST_IDLE_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_write && bus_addr == AW'(ADR_IDLE))
      |=> (bus_rdata[NCH-1:0] == ~$past(busy_i))); // R9

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q[c] && !(bus_valid && bus_write && bus_addr == AW'(ADR_PEND) && bus_wdata[c]))
        |=> pend_q[c]); // R6
    for (genvar k = 0; k < 5; k++) begin : g_bit
      AST_CAUSE_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        cause_i[c*5+k] |=> stat_q[c*5+k]); // R2
      AST_CAUSE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_q[c*5+k] && !(bus_valid && bus_write && bus_addr == AW'(ADR_CH0 + 2*c)))
          |=> stat_q[c*5+k]); // R3
    end
  end
endmodule

bind dma_irq_agg dma_irq_agg_chk #(.NCH(NCH), .AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cause_i(cause_i), .busy_i(busy_i),
  .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o),
  .stat_q(stat_q), .pend_q(pend_q), .gen_q(gen_q)
);

// File: tb/dma_irq_agg_bench.sv
module dma_irq_agg_bench;
  localparam int PERIOD = 10;
  localparam int NCH = 4;
  localparam int AW = 6;
  localparam int DW = 32;

  logic clk = 0, rst_n = 0;
  logic [NCH*5-1:0] cause_i = '0;
  logic [NCH-1:0] busy_i = '0;
  logic bus_valid = 0, bus_write = 0;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic irq_o;
  int checks = 0, failures = 0;
  bit done = 0;

  always #(PERIOD/2) clk = ~clk;

  dma_irq_agg #(.NCH(NCH), .AW(AW), .DW(DW)) u_dma_irq_agg (
    .clk(clk), .rst_n(rst_n), .cause_i(cause_i), .busy_i(busy_i),
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk);
    bus_valid = 1; bus_write = 1; bus_addr = AW'(a); bus_wdata = d;
    @(negedge clk);
    bus_valid = 0; bus_write = 0;
  endtask

  task automatic rd_chk(int a, logic [31:0] exp, string req);
    @(negedge clk);
    bus_valid = 1; bus_write = 0; bus_addr = AW'(a);
    @(negedge clk);
    bus_valid = 0;
    chk(req, bus_rdata, exp);
  endtask

  task automatic pulse(int c, logic [4:0] bits);
    @(negedge clk);
    cause_i[c*5 +: 5] = bits;
    @(negedge clk);
    cause_i = '0;
  endtask

  task automatic t_reset;
    rd_chk(0, 0, "R1 pending");
    rd_chk(1, 0, "R1 enable");
    for (int c = 0; c < NCH; c++) begin
      rd_chk(4 + 2*c, 0, "R1 cause");
      rd_chk(5 + 2*c, 0, "R1 mask");
    end
    chk("R1 irq", 32'(irq_o), 0);
  endtask

  task automatic t_event;
    pulse(1, 5'h04);
    rd_chk(6, 32'h4, "R2 cause set");
    rd_chk(0, 0, "R5 masked cause no pending");
    repeat (3) @(negedge clk);
    rd_chk(6, 32'h4, "R2 cause sticky");
    pulse(0, 5'h01);
    rd_chk(0, 0, "R5 masked ch0 no pending");
  endtask

  task automatic t_mask;
    wr(7, 32'h04);
    rd_chk(0, 32'h2, "R5 unmask raises pending");
    chk("R8 irq gated by enable", 32'(irq_o), 0);
    wr(1, 32'h2);
    chk("R8 irq enabled", 32'(irq_o), 1);
    wr(7, 32'hFFFF_FFE4);
    rd_chk(7, 32'h04, "R11 mask readback");
  endtask

  task automatic t_w1c;
    wr(0, 32'h0);
    rd_chk(0, 32'h2, "R6 write 0 no effect");
    wr(0, 32'h2);
    rd_chk(0, 32'h0, "R6 write 1 clears");
    chk("R8 irq low after clear", 32'(irq_o), 0);
    rd_chk(6, 32'h4, "R7 cause kept after pending clear");
    wr(6, 32'h0);
    rd_chk(6, 32'h0, "R3 zero write clears all");
    pulse(2, 5'h09);
    rd_chk(8, 32'h9, "R2 two causes");
    wr(8, 32'h08);
    rd_chk(8, 32'h8, "R3 partial clear");
  endtask

  task automatic t_collide;
    wr(11, 32'h1F);
    wr(1, 32'hF);
    chk("R8 no pending yet", 32'(irq_o), 0);
    @(negedge clk);
    cause_i[15] = 1'b1;
    bus_valid = 1; bus_write = 1; bus_addr = AW'(10); bus_wdata = 0;
    @(negedge clk);
    cause_i = '0; bus_valid = 0; bus_write = 0;
    chk("R5 pending same edge", 32'(irq_o), 1);
    rd_chk(10, 32'h1, "R4 event beats clear");
    wr(10, 32'h0);
    rd_chk(0, 32'h8, "R7 pending kept after cause clear");
    @(negedge clk);
    cause_i[19] = 1'b1;
    bus_valid = 1; bus_write = 1; bus_addr = AW'(0); bus_wdata = 32'h8;
    @(negedge clk);
    cause_i = '0; bus_valid = 0; bus_write = 0;
    rd_chk(0, 32'h8, "R6 set beats clear");
    wr(0, 32'h8);
    rd_chk(0, 32'h0, "R6 clear without event");
    chk("R8 irq low", 32'(irq_o), 0);
  endtask

  task automatic t_idle;
    busy_i = 4'b0101;
    rd_chk(2, 32'hA, "R9 idle");
    busy_i = 4'b1000;
    rd_chk(2, 32'h7, "R9 idle 2");
    rd_chk(3, 32'h0, "R10 unmapped");
    rd_chk(40, 32'h0, "R10 unmapped high");
    @(negedge clk);
    chk("R10 rdata not held", bus_rdata, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset;
    t_event;
    t_mask;
    t_w1c;
    t_collide;
    t_idle;
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(PERIOD*20000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule